// File: doc/BRIEF.md
# Paged Indirect Register Bridge

This block lets a management host reach a wide, paged internal register space through a handful of 16-bit window registers. All of them sit behind one fixed management device address. The host selects a page and turns on page access. It then writes a command word that carries a byte offset and an opcode. Payload moves through four 16-bit data registers, staged least significant chunk first, so one access can move up to 64 bits.

Once a command is accepted, the bridge raises an internal busy state. After a fixed latency it performs the access against a byte-addressed store. A write copies the four data chunks into eight consecutive bytes. A read copies eight consecutive bytes back into the data chunks. When the access is done, the bridge clears the opcode bits, so the host learns that the access has finished by polling the command word.

The host side is a plain register port with device, register, data, write strobe and read strobe. The serial management framing is outside this block.

Top module: `paged_reg_bridge`

## Requirements
- R1: Only device address 30 is answered. Writes to any other device address change nothing, and reads of any other device address return 0.
- R2: Window register 0x10 holds the page number in bits 15:8 and the page-access enable in bit 0. It reads back with bits 7:1 as 0.
- R3: Window register 0x11 holds the byte offset in bits 15:8, the write opcode in bit 0 and the read opcode in bit 1. It reads back with bits 7:2 as 0.
- R4: Window registers 0x18, 0x19, 0x1A and 0x1B are readable and writable 16-bit data chunks, with 0x18 as the least significant. Every other register offset reads as 0.
- R5: A write opcode stores the 64-bit data value little-endian into 8 consecutive bytes of the selected page, starting at the offset: the low byte of 0x18 goes to the offset byte. When both opcode bits are set, a write is performed.
- R6: A read opcode loads the 8 bytes starting at the offset into the data chunks, using the same byte order as R5.
- R7: After the clock edge that accepts a command, the opcode bits read back as set for exactly 4 cycles and read as 0 from then on.
- R8: A command written while the page enable is 0 performs no access, and its opcode bits read as 0 from the next cycle.
- R9: A write to 0x11 while an access is still busy is dropped, and the offset and opcode bits keep their values.
- R10: Byte offsets wrap modulo the page size (16 bytes), and page numbers alias modulo the page count (4).
- R11: After reset, all window registers read 0 and the store holds all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_dev | input | 5 | Management device address |
| host_reg | input | 5 | Window register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data, valid in the same cycle as host_rd, 0 otherwise |

## Verification
On every cycle the assertions check that the opcode bits are non-zero exactly while the sequencer is busy. They also check that every access completes exactly 4 cycles after acceptance, that a command written while busy leaves the offset untouched, and that a command issued with the page disabled never starts an access. The data path can only be shown through bench scenarios that compare the host-visible results against a byte-level model of the store: byte order, offset wrap, page aliasing, and data left unchanged after a disabled or dropped command.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
    localparam logic [4:0] BR_DEV_ADDR = 5'd30;
    localparam logic [4:0] WIN_PAGE    = 5'h10;
    localparam logic [4:0] WIN_CMD     = 5'h11;
    localparam logic [2:0] WIN_DATA_HI = 3'b110;   // 0x18..0x1B share bits 4:2
    localparam int CHUNK_W    = 16;
    localparam int CHUNKS     = 4;
    localparam int XFER_W     = CHUNK_W * CHUNKS;
    localparam int XFER_BYTES = XFER_W / 8;

    typedef struct packed {
        logic [7:0]        page;
        logic [7:0]        offset;
        logic              is_read;
        logic [XFER_W-1:0] wdata;
    } xfer_t;
endpackage

// File: rtl/bridge_window.sv
module bridge_window
    import bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [4:0]        host_dev,
    input  logic [4:0]        host_reg,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic              done_read_i,
    input  logic [XFER_W-1:0] rd_data_i,
    output logic              start_o,
    output xfer_t             xfer_o,
    output logic [1:0]        op_bits_o,
    output logic [7:0]        offset_o,
    output logic              page_en_o
);
    typedef struct packed {
        logic [7:0]        page;
        logic              page_en;
        logic [7:0]        offset;
        logic [1:0]        op;
        logic [XFER_W-1:0] data;
    } win_t;

    win_t win_d, win_q;
    logic hit_wr;
    logic hit_rd;
    logic is_data_reg;

    always_comb begin
        win_d       = win_q;
        start_o     = 1'b0;
        hit_wr      = host_wr && (host_dev == BR_DEV_ADDR);
        hit_rd      = host_rd && (host_dev == BR_DEV_ADDR);
        is_data_reg = (host_reg[4:2] == WIN_DATA_HI);

        if (hit_wr) begin
            if (host_reg == WIN_PAGE) begin
                win_d.page    = host_wdata[15:8];
                win_d.page_en = host_wdata[0];
            end else if (host_reg == WIN_CMD) begin
                if (!busy_i) begin
                    win_d.offset = host_wdata[15:8];
                    if (win_q.page_en && (host_wdata[1:0] != 2'b00)) begin
                        win_d.op = host_wdata[1:0];
                        start_o  = 1'b1;
                    end else begin
                        win_d.op = 2'b00;
                    end
                end
            end else if (is_data_reg) begin
                win_d.data[host_reg[1:0]*CHUNK_W +: CHUNK_W] = host_wdata;
            end
        end

        if (done_i) begin
            win_d.op = 2'b00;
            if (done_read_i) begin
                win_d.data = rd_data_i;
            end
        end

        xfer_o.page    = win_q.page;
        xfer_o.offset  = host_wdata[15:8];
        xfer_o.is_read = (host_wdata[1:0] == 2'b10);
        xfer_o.wdata   = win_q.data;

        host_rdata = '0;
        if (hit_rd) begin
            if (host_reg == WIN_PAGE) begin
                host_rdata = {win_q.page, 7'b0, win_q.page_en};
            end else if (host_reg == WIN_CMD) begin
                host_rdata = {win_q.offset, 6'b0, win_q.op};
            end else if (is_data_reg) begin
                host_rdata = win_q.data[host_reg[1:0]*CHUNK_W +: CHUNK_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign op_bits_o = win_q.op;
    assign offset_o  = win_q.offset;
    assign page_en_o = win_q.page_en;
endmodule

// File: rtl/bridge_seq.sv
module bridge_seq
    import bridge_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    input  xfer_t xfer_i,
    output logic  busy_o,
    output logic  done_o,
    output xfer_t xfer_o
);
    localparam int CNT_W = $clog2(LATENCY + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        xfer_t            xfer;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d  = seq_q;
        done_o = seq_q.busy && (seq_q.cnt == '0);
        if (done_o) begin
            seq_d.busy = 1'b0;
        end else if (seq_q.busy) begin
            seq_d.cnt = seq_q.cnt - 1'b1;
        end
        if (start_i) begin
            seq_d.busy = 1'b1;
            seq_d.cnt  = CNT_W'(LATENCY - 1);
            seq_d.xfer = xfer_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o = seq_q.busy;
    assign xfer_o = seq_q.xfer;
endmodule

// File: rtl/bridge_store.sv
module bridge_store
    import bridge_pkg::*;
#(
    parameter int NUM_PAGES  = 4,
    parameter int PAGE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  xfer_t             xfer_i,
    output logic [XFER_W-1:0] rd_data_o
);
    localparam int PG_W   = $clog2(NUM_PAGES);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int IDX_W  = PG_W + OFF_W;
    localparam int TOTAL  = NUM_PAGES * PAGE_BYTES;

    logic [TOTAL*8-1:0] mem_d, mem_q;
    logic [IDX_W-1:0]   byte_idx [XFER_BYTES];

    for (genvar b = 0; b < XFER_BYTES; b++) begin : g_lane
        logic [7:0] off_sum;
        assign off_sum      = xfer_i.offset + 8'(b);
        assign byte_idx[b]  = {xfer_i.page[PG_W-1:0], off_sum[OFF_W-1:0]};
        assign rd_data_o[b*8 +: 8] = mem_q[byte_idx[b]*8 +: 8];
    end

    always_comb begin
        mem_d = mem_q;
        if (done_i && !xfer_i.is_read) begin
            for (int b = 0; b < XFER_BYTES; b++) begin
                mem_d[byte_idx[b]*8 +: 8] = xfer_i.wdata[b*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/paged_reg_bridge.sv
module paged_reg_bridge
    import bridge_pkg::*;
#(
    parameter int LATENCY    = 4,
    parameter int NUM_PAGES  = 4,
    parameter int PAGE_BYTES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [4:0]  host_dev,
    input  logic [4:0]  host_reg,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata
);
    logic              start_w;
    logic              busy_w;
    logic              done_w;
    logic [1:0]        op_bits_w;
    logic [7:0]        offset_w;
    logic              page_en_w;
    xfer_t             cmd_xfer;
    xfer_t             act_xfer;
    logic [XFER_W-1:0] rd_data_w;

    bridge_window u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_dev   (host_dev),
        .host_reg   (host_reg),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy_i     (busy_w),
        .done_i     (done_w),
        .done_read_i(act_xfer.is_read),
        .rd_data_i  (rd_data_w),
        .start_o    (start_w),
        .xfer_o     (cmd_xfer),
        .op_bits_o  (op_bits_w),
        .offset_o   (offset_w),
        .page_en_o  (page_en_w)
    );

    bridge_seq #(.LATENCY(LATENCY)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_w),
        .xfer_i (cmd_xfer),
        .busy_o (busy_w),
        .done_o (done_w),
        .xfer_o (act_xfer)
    );

    bridge_store #(.NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_i   (done_w),
        .xfer_i   (act_xfer),
        .rd_data_o(rd_data_w)
    );
endmodule

// File: rtl/bridge_chk.sv
module bridge_chk #(
    parameter int LATENCY = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr,
    input logic [4:0] host_dev,
    input logic [4:0] host_reg,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [1:0] op_bits,
    input logic [7:0] offset,
    input logic       page_en
);
    logic [15:0] age_q;
    logic        cmd_wr;

    assign cmd_wr = host_wr && (host_dev == 5'd30) && (host_reg == 5'h11);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (start) begin
            age_q <= 16'd1;
        end else if (busy && !done) begin
            age_q <= age_q + 16'd1;
        end
    end

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (age_q == 16'(LATENCY)));

    assert_opbits_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_bits != 2'b00) == busy);

    assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && op_bits == 2'b00));

    assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> $stable(offset));

    assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && !page_en) |=> !busy);
endmodule

bind paged_reg_bridge bridge_chk #(.LATENCY(LATENCY)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .host_wr (host_wr),
    .host_dev(host_dev),
    .host_reg(host_reg),
    .start   (start_w),
    .busy    (busy_w),
    .done    (done_w),
    .op_bits (op_bits_w),
    .offset  (offset_w),
    .page_en (page_en_w)
);

// File: tb/sim_paged_reg_bridge.sv
module sim_paged_reg_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [4:0]  host_dev = '0;
    logic [4:0]  host_reg = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    logic [7:0] model [4][16];

    localparam logic [4:0] DEV = 5'd30;

    always #2.5 clk = ~clk;

    paged_reg_bridge u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_dev  (host_dev),
        .host_reg  (host_reg),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    // monitor: pops expected items while a read strobe is presented
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (host_rd && sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                tests++;
                if (host_rdata !== it.exp) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h", it.tag, host_rdata, it.exp);
                end
            end
        end
    end

    task automatic hw(input logic [4:0] dev, input logic [4:0] r, input logic [15:0] d);
        host_wr = 1'b1; host_dev = dev; host_reg = r; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hr(input logic [4:0] dev, input logic [4:0] r,
                      input logic [15:0] exp, input string tag);
        item_t it;
        it.exp = exp; it.tag = tag;
        sb.push_back(it);
        host_rd = 1'b1; host_dev = dev; host_reg = r;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mdl_write(input int pg, input int off, input logic [63:0] v);
        for (int b = 0; b < 8; b++) model[pg % 4][(off + b) % 16] = v[b*8 +: 8];
    endtask

    function automatic logic [15:0] chunk(input int pg, input int off, input int c);
        return {model[pg % 4][(off + 2*c + 1) % 16], model[pg % 4][(off + 2*c) % 16]};
    endfunction

    task automatic load_data(input logic [63:0] v);
        for (int c = 0; c < 4; c++) hw(DEV, 5'(5'h18 + c), v[c*16 +: 16]);
    endtask

    task automatic check_data_model(input int pg, input int off, input string tag);
        for (int c = 0; c < 4; c++) hr(DEV, 5'(5'h18 + c), chunk(pg, off, c), tag);
    endtask

    initial begin
        for (int p = 0; p < 4; p++) for (int b = 0; b < 16; b++) model[p][b] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        hr(DEV, 5'h10, 16'h0000, "R11 page");
        hr(DEV, 5'h11, 16'h0000, "R11 cmd");
        for (int c = 0; c < 4; c++) hr(DEV, 5'(5'h18 + c), 16'h0000, "R11 data");

        // R1 foreign device
        hw(5'd3, 5'h10, 16'h0101);
        hr(DEV, 5'h10, 16'h0000, "R1 foreign write ignored");

        // R2 page register
        hw(DEV, 5'h10, 16'h01FF);
        hr(DEV, 5'h10, 16'h0101, "R2 page readback");

        // R4 data chunks
        load_data(64'h7788_5566_3344_1122);
        hr(DEV, 5'h18, 16'h1122, "R4 chunk0");
        hr(DEV, 5'h1B, 16'h7788, "R4 chunk3");
        hr(DEV, 5'h12, 16'h0000, "R4 unmapped");
        hr(5'd3, 5'h18, 16'h0000, "R1 foreign read");

        // R5 write op + R7 timing (R3 readback format)
        hw(DEV, 5'h11, 16'h03FD);   // offset 3, write, junk bits dropped
        mdl_write(1, 3, 64'h7788_5566_3344_1122);
        hr(DEV, 5'h11, 16'h0301, "R3 R7 busy cycle1");
        idle(2);
        hr(DEV, 5'h11, 16'h0301, "R7 busy cycle4");
        hr(DEV, 5'h11, 16'h0300, "R7 cleared cycle5");

        // R6 read op restores data
        load_data(64'h0);
        hw(DEV, 5'h11, 16'h0302);
        idle(5);
        check_data_model(1, 3, "R6 R5 readback");

        // R10 wrap and alias
        load_data(64'h0102_EEFF_CCDD_AABB);
        hw(DEV, 5'h11, 16'h0E01);
        mdl_write(1, 14, 64'h0102_EEFF_CCDD_AABB);
        idle(5);
        hw(DEV, 5'h10, 16'h0501);
        hw(DEV, 5'h11, 16'h0802);
        idle(5);
        check_data_model(1, 8, "R10 wrap/alias");

        // R8 page disabled
        hw(DEV, 5'h10, 16'h0200);
        load_data(64'hDEAD_BEEF_CAFE_F00D);
        hw(DEV, 5'h11, 16'h0001);
        hr(DEV, 5'h11, 16'h0000, "R8 opcode cleared");
        idle(5);
        hw(DEV, 5'h10, 16'h0201);
        hw(DEV, 5'h11, 16'h0002);
        idle(5);
        check_data_model(2, 0, "R8 no access");

        // R9 command during busy dropped
        load_data(64'h0807_0605_0403_0201);
        hw(DEV, 5'h11, 16'h0401);
        mdl_write(2, 4, 64'h0807_0605_0403_0201);
        hw(DEV, 5'h11, 16'h0902);
        hr(DEV, 5'h11, 16'h0401, "R9 dropped");
        idle(4);
        hr(DEV, 5'h11, 16'h0400, "R9 completion");
        load_data(64'h0);
        hw(DEV, 5'h11, 16'h0402);
        idle(5);
        check_data_model(2, 4, "R9 data intact");

        // R5 both opcode bits -> write
        load_data(64'h1111_2222_3333_4444);
        hw(DEV, 5'h11, 16'h0A03);
        mdl_write(2, 10, 64'h1111_2222_3333_4444);
        hr(DEV, 5'h11, 16'h0A03, "R5 both bits busy");
        idle(5);
        load_data(64'h0);
        hw(DEV, 5'h11, 16'h0A02);
        idle(5);
        check_data_model(2, 10, "R5 both bits write");

        idle(2);
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule